// File: doc/BRIEF.md
# Single-Cycle Fast-Case ALU

This block is a shortcut beside the two-cycle 64-bit integer ALU of the first execution lane. It looks at each issued operation together with its operands. When it can produce an exact result after one clock, it presents that result with a fast-valid flag so that the forwarding network can hand it to a dependent instruction one cycle early. The two-cycle ALU still computes every operation, and its result stays authoritative. Wherever the fast flag is set, the two results agree.

Three kinds of operation are served. The first is 32-bit add and subtract, with the 64-bit result either sign-extended or zero-extended. The second is bitwise AND, OR and XOR on all 64 bits. The third is full 64-bit add and subtract, but only when both operands are small enough that a 32-bit adder gives the exact answer. For that third kind, the high bits of each operand are checked for uniformity, and the fast path declines whenever either operand falls outside that window. Every other opcode leaves the flag low.

The reset input is asserted asynchronously and released synchronously inside the block, through two flops.

Top module: `fastalu_lane0`

## Requirements
- R1: After reset is released and before any qualifying issue, `fast_vld` is 0 and `fast_res` is 0.
- R2: Opcodes 2 (word add) and 3 (word subtract) always qualify. One clock after issue, `fast_res` is the low 32 bits of a+b or a-b, sign-extended to 64 bits.
- R3: Opcodes 4 (word add) and 5 (word subtract) always qualify. One clock after issue, `fast_res` is the low 32 bits of a+b or a-b, zero-extended to 64 bits.
- R4: Opcodes 0 (add) and 1 (subtract) qualify when both operands, read as signed values, lie in [-2^30, 2^30-1]. `fast_res` is then the exact 64-bit a+b or a-b.
- R5: Opcodes 0 and 1 with either operand outside [-2^30, 2^30-1] leave `fast_vld` at 0 on the following cycle.
- R6: Opcodes 6 (AND), 7 (OR) and 8 (XOR) always qualify and give the full 64-bit bitwise result.
- R7: Opcodes 9 to 15 never qualify, so `fast_vld` is 0 on the following cycle.
- R8: When `lane_vld` is 0 at a clock edge, `fast_vld` is 0 after that edge, whatever the opcode and operands are.
- R9: `fast_res` keeps its previous value across any edge at which no qualifying operation is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_vld | input | 1 | An operation is issued on the first lane this cycle |
| lane_op | input | 4 | Operation code (0..15) |
| lane_a | input | 64 | First operand |
| lane_b | input | 64 | Second operand |
| fast_vld | output | 1 | Registered: `fast_res` is exact for the previous issue |
| fast_res | output | 64 | Registered fast result |

## Verification
The range qualifier and the short adder act on the same edge, and the hard case is a 64-bit add or subtract whose operands sit exactly on the window edges. An example is 2^30-1 plus 2^30-1, which must be accepted and summed exactly. Another is -2^30 minus 2^30-1, which must also be accepted. By contrast, 2^30 or -2^30-1 in either position must be declined. The bench mixes these edge values with random wide and narrow operands. It holds each outcome against a behavioural model of the two-cycle ALU, which uses plain signed 64-bit arithmetic. That model demands both the correct flag and, when the flag is set, a bit-exact result.

// File: rtl/fastalu_pkg.sv
package fastalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD64  = 4'd0,
    OP_SUB64  = 4'd1,
    OP_ADDW_S = 4'd2,
    OP_SUBW_S = 4'd3,
    OP_ADDW_U = 4'd4,
    OP_SUBW_U = 4'd5,
    OP_AND    = 4'd6,
    OP_OR     = 4'd7,
    OP_XOR    = 4'd8
  } fast_op_e;

  typedef enum logic [2:0] {
    SEL_SEXT = 3'd0,
    SEL_ZEXT = 3'd1,
    SEL_AND  = 3'd2,
    SEL_OR   = 3'd3,
    SEL_XOR  = 3'd4
  } res_sel_e;

endpackage

// File: rtl/fastalu_qualify.sv
module fastalu_qualify
  import fastalu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int SAFE_BITS = 30
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              qual,
  output logic              sub,
  output res_sel_e          sel
);
  localparam int HI_W = DATA_W - SAFE_BITS;

  logic [HI_W-1:0] a_hi, b_hi;
  logic            a_small, b_small;

  assign a_hi    = a[DATA_W-1:SAFE_BITS];
  assign b_hi    = b[DATA_W-1:SAFE_BITS];
  assign a_small = (&a_hi) | ~(|a_hi);
  assign b_small = (&b_hi) | ~(|b_hi);

  always_comb begin
    qual = 1'b0;
    sub  = 1'b0;
    sel  = SEL_SEXT;
    case (op)
      OP_ADD64:  begin qual = a_small & b_small; end
      OP_SUB64:  begin qual = a_small & b_small; sub = 1'b1; end
      OP_ADDW_S: begin qual = 1'b1; end
      OP_SUBW_S: begin qual = 1'b1; sub = 1'b1; end
      OP_ADDW_U: begin qual = 1'b1; sel = SEL_ZEXT; end
      OP_SUBW_U: begin qual = 1'b1; sub = 1'b1; sel = SEL_ZEXT; end
      OP_AND:    begin qual = 1'b1; sel = SEL_AND; end
      OP_OR:     begin qual = 1'b1; sel = SEL_OR; end
      OP_XOR:    begin qual = 1'b1; sel = SEL_XOR; end
      default:   begin qual = 1'b0; end
    endcase
  end
endmodule

// File: rtl/fastalu_word_adder.sv
module fastalu_word_adder #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sub,
  output logic [WORD_W-1:0] sum
);
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W:0]   raw;

  assign b_eff = sub ? ~b : b;
  assign raw   = {1'b0, a} + {1'b0, b_eff} + {{WORD_W{1'b0}}, sub};
  assign sum   = raw[WORD_W-1:0];
endmodule

// File: rtl/fastalu_logic.sv
module fastalu_logic #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y_and,
  output logic [DATA_W-1:0] y_or,
  output logic [DATA_W-1:0] y_xor
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y_and[i] = a[i] & b[i];
    assign y_or[i]  = a[i] | b[i];
    assign y_xor[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/fastalu_lane0.sv
module fastalu_lane0
  import fastalu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int WORD_W    = 32,
  parameter int SAFE_BITS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lane_vld,
  input  logic [3:0]        lane_op,
  input  logic [DATA_W-1:0] lane_a,
  input  logic [DATA_W-1:0] lane_b,
  output logic              fast_vld,
  output logic [DATA_W-1:0] fast_res
);
  localparam int EXT_W = DATA_W - WORD_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              qual, sub;
  res_sel_e          sel;
  logic [WORD_W-1:0] wsum;
  logic [DATA_W-1:0] y_and, y_or, y_xor;

  fastalu_qualify #(.DATA_W(DATA_W), .SAFE_BITS(SAFE_BITS)) u_qual (
    .op(lane_op), .a(lane_a), .b(lane_b), .qual(qual), .sub(sub), .sel(sel)
  );

  fastalu_word_adder #(.WORD_W(WORD_W)) u_add (
    .a(lane_a[WORD_W-1:0]), .b(lane_b[WORD_W-1:0]), .sub(sub), .sum(wsum)
  );

  fastalu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(lane_a), .b(lane_b), .y_and(y_and), .y_or(y_or), .y_xor(y_xor)
  );

  // next-state
  logic              vld_nxt, res_en;
  logic [DATA_W-1:0] res_nxt;

  always_comb begin
    vld_nxt = lane_vld & qual;
    res_en  = vld_nxt;
    case (sel)
      SEL_ZEXT: res_nxt = {{EXT_W{1'b0}}, wsum};
      SEL_AND:  res_nxt = y_and;
      SEL_OR:   res_nxt = y_or;
      SEL_XOR:  res_nxt = y_xor;
      default:  res_nxt = {{EXT_W{wsum[WORD_W-1]}}, wsum};
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fast_vld <= 1'b0;
      fast_res <= '0;
    end else begin
      fast_vld <= vld_nxt;
      if (res_en) fast_res <= res_nxt;
    end
  end

  // assertions
  AST_WORD_SEXT_OK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_vld && (lane_op == OP_ADDW_S || lane_op == OP_SUBW_S)) |=>
      (fast_vld && fast_res[DATA_W-1:WORD_W] == {EXT_W{fast_res[WORD_W-1]}})); // R2
  AST_WORD_ZEXT_OK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_vld && (lane_op == OP_ADDW_U || lane_op == OP_SUBW_U)) |=>
      (fast_vld && fast_res[DATA_W-1:WORD_W] == '0)); // R3
  AST_WIDE_DECLINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_vld && (lane_op == OP_ADD64 || lane_op == OP_SUB64) &&
     ($signed(lane_a) > $signed(64'sd1073741823) || $signed(lane_a) < -$signed(64'sd1073741824) ||
      $signed(lane_b) > $signed(64'sd1073741823) || $signed(lane_b) < -$signed(64'sd1073741824)))
      |=> !fast_vld); // R5
  AST_LOGIC_OK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_vld && (lane_op == OP_AND || lane_op == OP_OR || lane_op == OP_XOR)) |=> fast_vld); // R6
  AST_OTHER_OP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_vld && lane_op > 4'd8) |=> !fast_vld); // R7
  AST_IDLE_LANE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lane_vld |=> !fast_vld); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(lane_vld && qual) |=> $stable(fast_res)); // R9
endmodule

// File: tb/fastalu_lane0_test.sv
`timescale 1ns/1ps
module fastalu_lane0_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lane_vld;
  logic [3:0]  lane_op;
  logic [63:0] lane_a, lane_b;
  logic        fast_vld;
  logic [63:0] fast_res;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state: what the outputs must show after the next edge
  logic        exp_v;
  logic [63:0] exp_r;
  string       exp_tag;

  always #2.5 clk = ~clk;

  fastalu_lane0 uut (
    .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_op(lane_op),
    .lane_a(lane_a), .lane_b(lane_b), .fast_vld(fast_vld), .fast_res(fast_res)
  );

  function automatic bit in_win(logic [63:0] x);
    longint s = $signed(x);
    return (s >= -64'sd1073741824) && (s <= 64'sd1073741823);
  endfunction

  // behavioural two-cycle ALU result
  function automatic logic [63:0] slow_alu(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic [31:0] w;
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: begin w = a[31:0] + b[31:0]; return {{32{w[31]}}, w}; end
      4'd3: begin w = a[31:0] - b[31:0]; return {{32{w[31]}}, w}; end
      4'd4: begin w = a[31:0] + b[31:0]; return {32'd0, w}; end
      4'd5: begin w = a[31:0] - b[31:0]; return {32'd0, w}; end
      4'd6: return a & b;
      4'd7: return a | b;
      4'd8: return a ^ b;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    check({exp_tag, " valid"}, fast_vld === exp_v, {63'd0, fast_vld}, {63'd0, exp_v});
    if (exp_v) check({exp_tag, " result"}, fast_res === exp_r, fast_res, exp_r);
    else       check("R9 held result", fast_res === exp_r, fast_res, exp_r);
  endtask

  // one cycle: judge the previous issue, then drive a new one
  task automatic step(bit v, logic [3:0] op, logic [63:0] a, logic [63:0] b);
    bit q;
    @(negedge clk);
    compare_now();
    lane_vld = v; lane_op = op; lane_a = a; lane_b = b;
    case (op)
      4'd0, 4'd1: q = in_win(a) && in_win(b);
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: q = 1'b1;
      default: q = 1'b0;
    endcase
    if (!v)                  exp_tag = "R8";
    else if (op <= 4'd1)     exp_tag = q ? "R4" : "R5";
    else if (op <= 4'd3)     exp_tag = "R2";
    else if (op <= 4'd5)     exp_tag = "R3";
    else if (op <= 4'd8)     exp_tag = "R6";
    else                     exp_tag = "R7";
    exp_v = v && q;
    if (exp_v) exp_r = slow_alu(op, a, b);
  endtask

  function automatic logic [63:0] pick_operand();
    logic [63:0] edges [8] = '{64'h3FFF_FFFF, 64'h4000_0000, 64'hFFFF_FFFF_C000_0000,
                               64'hFFFF_FFFF_BFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
                               64'h7FFF_FFFF, 64'h8000_0000_0000_0000};
    int k = $urandom_range(0, 3);
    case (k)
      0: return edges[$urandom_range(0, 7)];
      1: return {{34{1'b0}}, 30'($urandom)};
      2: return {{34{1'b1}}, 30'($urandom)};
      default: return {32'($urandom), 32'($urandom)};
    endcase
  endfunction

  initial begin
    logic [63:0] bnd [6] = '{64'h3FFF_FFFF, 64'h4000_0000, 64'hFFFF_FFFF_C000_0000,
                             64'hFFFF_FFFF_BFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF};
    rst_n = 1'b0; lane_vld = 1'b0; lane_op = 4'd0; lane_a = '0; lane_b = '0;
    exp_v = 1'b0; exp_r = '0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", fast_vld === 1'b0, {63'd0, fast_vld}, 64'd0);
    check("R1 result", fast_res === 64'd0, fast_res, 64'd0);
    exp_tag = "R1";

    // directed window edges for wide add and subtract (R4, R5)
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          step(1'b1, 4'(op), bnd[i], bnd[j]);
    // word ops with carries across bit 31 (R2, R3)
    for (int op = 2; op < 6; op++) begin
      step(1'b1, 4'(op), 64'h1234_5678_FFFF_FFFF, 64'd1);
      step(1'b1, 4'(op), 64'hAAAA_0000_0000_0000, 64'd1);
      step(1'b1, 4'(op), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    end
    // logic ops on full-width patterns (R6)
    for (int op = 6; op < 9; op++)
      step(1'b1, 4'(op), 64'hF0F0_1234_8000_0001, 64'h0FF0_FFFF_8000_0003);
    // other opcodes and an idle lane must not disturb the held result (R7, R8, R9)
    step(1'b1, 4'd6, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int op = 9; op < 16; op++) step(1'b1, 4'(op), 64'h5, 64'h7);
    step(1'b0, 4'd2, 64'h1, 64'h1);
    step(1'b0, 4'd6, 64'hFFFF, 64'hFFFF);
    step(1'b1, 4'd0, 64'h4000_0000, 64'd1);
    // random mix
    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)), pick_operand(), pick_operand());
    step(1'b0, 4'd0, 64'd0, 64'd0);
    @(negedge clk);
    compare_now();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule